// File: doc/BRIEF.md
# EEPROM Write Guard and Status Byte Unit

This unit sits beside the command engine of a small serial EEPROM controller. It holds the write-enable latch and the two retained block-protect bits, and it assembles the status byte that a status read returns. It also decides, at the moment chip select is released, whether a pending array or status write may start its internal programming cycle. The command engine reports the decoded events as single-cycle strobes. These are: an enable command, a disable command, an armed array write with its page address, an armed status write with its data byte, and each further bit shifted while select is low. The unit also samples the write-protect pin, the chip-select pin and a busy flag from the write timer.

A granted write shows as a one-cycle grant pulse. From that cycle until the timer's busy flag has risen and dropped again, the status byte reads all ones. When the cycle completes, the write-enable latch clears. A write that is refused is dropped without any indication, and the latch keeps its value. The one exception is a write cancelled by the protect pin falling while select is still low, which raises a one-cycle abort pulse.

Top module: `wguard_top`

## Requirements
- R1: After reset the status byte is 0x00 and neither commit_grant nor write_abort is high.
- R2: While no write cycle runs, the status byte is {4'b0000, protect[1:0], wel, 1'b0}: bit 0 is write-in-progress, bit 1 the enable latch, bits 3:2 the protect code, and bits 7:4 read 0.
- R3: An en_set strobe sets the latch only when cs_n rises with no bit_tick between the strobe and that rise. A bit_tick in between discards it.
- R4: An en_clr strobe clears the latch on the next clock.
- R5: An array write to page p (byte address p*4) is refused if it is locked. Code 01 locks 0x180–0x1FF, code 10 locks 0x100–0x1FF, code 11 locks everything, and code 00 locks nothing. Status writes ignore the protect code.
- R6: A commit is granted only if the latch is set, wp_n is high, no write cycle is running and cyc_busy is low. A refused write leaves the latch unchanged.
- R7: A grant is a single-cycle commit_grant pulse, seen in the cycle after cs_n is sampled high. The status byte reads 0xFF from that cycle on.
- R8: After a grant, once cyc_busy has been high and then goes low, the status byte returns to the R2 layout with the latch cleared.
- R9: A granted status write copies only data bits 3:2 into the protect code. All other data bits have no effect.
- R10: A wp_n fall while cs_n is low and a write is pending gives a one-cycle write_abort in the next cycle. The pending write is then never granted.
- R11: A wp_n fall during a running write cycle neither aborts it nor alters its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, low = selected |
| wp_n | input | 1 | Write protect, low = writes blocked |
| bit_tick | input | 1 | Strobe for each further bit shifted while selected |
| en_set | input | 1 | Enable command fully received |
| en_clr | input | 1 | Disable command fully received |
| arr_arm | input | 1 | Array write armed (opcode, address and data byte received) |
| arr_page | input | ADDR_W-log2(PAGE_BYTES) | Page address of the armed array write |
| st_arm | input | 1 | Status write armed |
| st_data | input | 8 | Data byte of the status write |
| cyc_busy | input | 1 | Busy flag from the write timer |
| status_byte | output | 8 | Status byte |
| commit_grant | output | 1 | One-cycle pulse: write may start |
| write_abort | output | 1 | One-cycle pulse: pending write cancelled by protect pin |

## Verification
On every cycle, the assertions check the following: no grant occurs without an enabled latch, a high protect pin and an idle cycle; a grant never targets a locked page; grant and abort never fire together; the latch only sets on a select release and clears when a cycle completes; and the protect code only changes with a grant. The bench scenarios are needed for the rest. They show the exact status values, the whole protection map across boundary pages for all four codes, the discarded enable when further bits arrive, the masking of the junk status-write bits, and that a late protect-pin drop leaves a running cycle alone.

// File: rtl/wguard_pkg.sv
package wguard_pkg;
   typedef enum logic {WK_ARRAY = 1'b0, WK_STATUS = 1'b1} wkind_e;
   localparam int ST_WIP = 0;
   localparam int ST_WEL = 1;
   localparam int ST_BP  = 2;
   localparam int BP_W   = 2;
   localparam int ST_W   = 8;
endpackage

// File: rtl/wguard_latch.sv
module wguard_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_rise,
   input  logic bit_tick,
   input  logic en_set,
   input  logic en_clr,
   input  logic cycle_done,
   output logic wel
);
   logic arm_q, wel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         wel_q <= 1'b0;
      end else begin
         if (en_set && !cs_rise)
            arm_q <= 1'b1;
         else if (bit_tick || cs_rise)
            arm_q <= 1'b0;

         if (cycle_done || en_clr)
            wel_q <= 1'b0;
         else if (cs_rise && (arm_q || en_set) && !bit_tick)
            wel_q <= 1'b1;
      end
   end

   assign wel = wel_q;

   // R8: completion clears the latch
   a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done |=> !wel_q);
   // R3: latch only sets on a select release
   a_r3_set_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel_q) |-> $past(cs_rise));
   // R4: disable strobe wins
   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr |=> !wel_q);
endmodule

// File: rtl/wguard_protect.sv
module wguard_protect #(
   parameter int PAGE_W = 7
) (
   input  logic [1:0]        bp,
   input  logic [PAGE_W-1:0] page,
   output logic              locked
);
   localparam int NQ = 4;

   if (PAGE_W < 2) begin : g_bad_width
      $error("wguard_protect: PAGE_W must be at least 2");
   end

   logic [NQ-1:0] qlock;
   logic [1:0]    quarter;

   assign quarter = page[PAGE_W-1 -: 2];

   for (genvar q = 0; q < NQ; q++) begin : g_quarter
      localparam bit UPPER_HALF = (q >= 2);
      localparam bit TOP_QUART  = (q == 3);
      assign qlock[q] = (bp == 2'b11)
                      | ((bp == 2'b10) & UPPER_HALF)
                      | ((bp == 2'b01) & TOP_QUART);
   end

   assign locked = qlock[quarter];
endmodule

// File: rtl/wguard_cycle.sv
module wguard_cycle
   import wguard_pkg::*;
#(
   parameter int PAGE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              cs_rise,
   input  logic              wp_n,
   input  logic              wp_fall,
   input  logic              arr_arm,
   input  logic [PAGE_W-1:0] arr_page,
   input  logic              st_arm,
   input  logic [BP_W-1:0]   st_bp,
   input  logic              cyc_busy,
   input  logic              wel,
   input  logic              locked,
   output logic [PAGE_W-1:0] pend_page,
   output logic              grant,
   output logic              abort,
   output logic              wip,
   output logic              cycle_done,
   output logic [BP_W-1:0]   bp
);
   logic              pend_q, grant_q, abort_q, wip_q, seen_q;
   wkind_e            kind_q;
   logic [PAGE_W-1:0] page_q;
   logic [BP_W-1:0]   data_q, bp_q;
   logic              ok, kill;

   assign ok = pend_q && cs_rise && wel && wp_n && !wip_q && !cyc_busy
             && ((kind_q == WK_STATUS) || !locked);
   assign kill = pend_q && wp_fall && !cs_n;
   assign cycle_done = wip_q && seen_q && !cyc_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         kind_q  <= WK_ARRAY;
         page_q  <= '0;
         data_q  <= '0;
         grant_q <= 1'b0;
         abort_q <= 1'b0;
         wip_q   <= 1'b0;
         seen_q  <= 1'b0;
         bp_q    <= '0;
      end else begin
         if (arr_arm || st_arm) begin
            pend_q <= 1'b1;
            kind_q <= st_arm ? WK_STATUS : WK_ARRAY;
            page_q <= arr_page;
            data_q <= st_bp;
         end else if (cs_rise || kill) begin
            pend_q <= 1'b0;
         end

         grant_q <= ok;
         abort_q <= kill;

         if (ok) begin
            wip_q  <= 1'b1;
            seen_q <= 1'b0;
            if (kind_q == WK_STATUS) bp_q <= data_q;
         end else if (wip_q) begin
            if (cyc_busy) seen_q <= 1'b1;
            if (cycle_done) wip_q <= 1'b0;
         end
      end
   end

   assign pend_page = page_q;
   assign grant     = grant_q;
   assign abort     = abort_q;
   assign wip       = wip_q;
   assign bp        = bp_q;

   // R6: grant only with latch set, protect pin high and idle cycle
   a_r6_grant_gated: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q |-> ($past(wel) && $past(wp_n) && !$past(wip_q)));
   // R5: never grant into a locked page
   a_r5_no_locked: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q |-> (($past(kind_q) == WK_STATUS) || !$past(locked)));
   // R10: abort only after a protect-pin drop with select low
   a_r10_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |-> ($past(!cs_n) && !$past(wp_n)));
   // R10: grant and abort are exclusive
   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant_q, abort_q}));
   // R8: write-in-progress falls only with timer idle
   a_r8_wip_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip_q) |-> !$past(cyc_busy));
   // R9: protect code changes only with a grant
   a_r9_bp_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bp_q) |-> grant_q);
endmodule

// File: rtl/wguard_top.sv
module wguard_top
   import wguard_pkg::*;
#(
   parameter int ADDR_W     = 9,
   parameter int PAGE_BYTES = 4,
   localparam int PG_LSB    = $clog2(PAGE_BYTES),
   localparam int PAGE_W    = ADDR_W - PG_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wp_n,
   input  logic              bit_tick,
   input  logic              en_set,
   input  logic              en_clr,
   input  logic              arr_arm,
   input  logic [PAGE_W-1:0] arr_page,
   input  logic              st_arm,
   input  logic [ST_W-1:0]   st_data,
   input  logic              cyc_busy,
   output logic [ST_W-1:0]   status_byte,
   output logic              commit_grant,
   output logic              write_abort
);
   if ((1 << PG_LSB) != PAGE_BYTES) begin : g_bad_page
      $error("wguard_top: PAGE_BYTES must be a power of two");
   end
   if (PAGE_W < 2) begin : g_bad_addr
      $error("wguard_top: address too narrow for four protect quarters");
   end

   logic cs_q, wp_q, cs_rise, wp_fall;
   logic wel, wip, cycle_done, locked;
   logic [PAGE_W-1:0] pend_page;
   logic [BP_W-1:0]   bp;
   logic unused_st_bits;

   assign unused_st_bits = ^{st_data[7:4], st_data[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= 1'b1;
         wp_q <= 1'b1;
      end else begin
         cs_q <= cs_n;
         wp_q <= wp_n;
      end
   end

   assign cs_rise = cs_n & ~cs_q;
   assign wp_fall = ~wp_n & wp_q;

   wguard_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_rise    (cs_rise),
      .bit_tick   (bit_tick),
      .en_set     (en_set),
      .en_clr     (en_clr),
      .cycle_done (cycle_done),
      .wel        (wel)
   );

   wguard_protect #(.PAGE_W(PAGE_W)) u_protect (
      .bp     (bp),
      .page   (pend_page),
      .locked (locked)
   );

   wguard_cycle #(.PAGE_W(PAGE_W)) u_cycle (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .cs_rise    (cs_rise),
      .wp_n       (wp_n),
      .wp_fall    (wp_fall),
      .arr_arm    (arr_arm),
      .arr_page   (arr_page),
      .st_arm     (st_arm),
      .st_bp      (st_data[ST_BP +: BP_W]),
      .cyc_busy   (cyc_busy),
      .wel        (wel),
      .locked     (locked),
      .pend_page  (pend_page),
      .grant      (commit_grant),
      .abort      (write_abort),
      .wip        (wip),
      .cycle_done (cycle_done),
      .bp         (bp)
   );

   always_comb begin
      if (wip) begin
         status_byte = '1;
      end else begin
         status_byte = '0;
         status_byte[ST_WEL] = wel;
         status_byte[ST_BP +: BP_W] = bp;
      end
   end

   // R7: status reads all ones in the grant cycle
   a_r7_ff_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
      commit_grant |-> (status_byte == 8'hFF));
endmodule

// File: tb/tb_wguard_top.sv
`timescale 1ns/100ps
module tb_wguard_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, wp_n = 1'b1, bit_tick = 1'b0, en_set = 1'b0, en_clr = 1'b0;
   logic arr_arm = 1'b0, st_arm = 1'b0, cyc_busy = 1'b0;
   logic [6:0] arr_page = '0;
   logic [7:0] st_data = '0;
   logic [7:0] status_byte;
   logic commit_grant, write_abort;
   int checks = 0, errors = 0;
   logic g, a;

   always #2.5 clk = ~clk;

   wguard_top dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .bit_tick(bit_tick),
      .en_set(en_set), .en_clr(en_clr), .arr_arm(arr_arm), .arr_page(arr_page),
      .st_arm(st_arm), .st_data(st_data), .cyc_busy(cyc_busy),
      .status_byte(status_byte), .commit_grant(commit_grant), .write_abort(write_abort)
   );

   // {protect code, page, expected grant}
   localparam logic [9:0] VEC [10] = '{
      {2'd0, 7'h7F, 1'b1}, {2'd1, 7'h5F, 1'b1}, {2'd1, 7'h60, 1'b0},
      {2'd1, 7'h7F, 1'b0}, {2'd2, 7'h3F, 1'b1}, {2'd2, 7'h40, 1'b0},
      {2'd2, 7'h5F, 1'b0}, {2'd3, 7'h00, 1'b0}, {2'd3, 7'h20, 1'b0},
      {2'd0, 7'h00, 1'b1}
   };

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wren(input logic extra_bit);
      cs_n = 1'b0; en_set = 1'b1; tick();
      en_set = 1'b0;
      if (extra_bit) begin bit_tick = 1'b1; tick(); bit_tick = 1'b0; end
      cs_n = 1'b1; tick();
   endtask

   task automatic wrdi();
      cs_n = 1'b0; en_clr = 1'b1; tick();
      en_clr = 1'b0; cs_n = 1'b1; tick();
   endtask

   task automatic wr_seq(input logic is_st, input logic [6:0] pg, input logic [7:0] d,
                         output logic og, output logic oa);
      cs_n = 1'b0; arr_arm = !is_st; st_arm = is_st; arr_page = pg; st_data = d; tick();
      arr_arm = 1'b0; st_arm = 1'b0; cs_n = 1'b1; tick();
      og = commit_grant; oa = write_abort;
   endtask

   task automatic finish_busy();
      cyc_busy = 1'b1; tick();
      cyc_busy = 1'b0; tick();
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1; tick();
      chk("R1 reset status", status_byte, 8'h00);
      chk("R1 reset pulses", {6'b0, commit_grant, write_abort}, 8'h00);

      wren(1'b0);
      chk("R2 latch bit", status_byte, 8'h02);
      wrdi();
      chk("R4 disable", status_byte, 8'h00);
      wren(1'b1);
      chk("R3 extra bit discards enable", status_byte, 8'h00);

      wr_seq(1'b0, 7'h10, 8'h00, g, a);
      chk("R6 no latch no grant", {7'b0, g}, 8'h00);
      wren(1'b0);
      wp_n = 1'b0; tick(); tick();
      wr_seq(1'b0, 7'h10, 8'h00, g, a);
      chk("R6 wp low no grant", {7'b0, g}, 8'h00);
      chk("R6 latch kept", status_byte, 8'h02);
      wp_n = 1'b1; tick();
      cyc_busy = 1'b1;
      wr_seq(1'b0, 7'h10, 8'h00, g, a);
      cyc_busy = 1'b0;
      chk("R6 busy no grant", {7'b0, g}, 8'h00);

      wr_seq(1'b0, 7'h10, 8'h00, g, a);
      chk("R7 grant", {7'b0, g}, 8'h01);
      chk("R7 status all ones", status_byte, 8'hFF);
      tick();
      chk("R7 single pulse", {7'b0, commit_grant}, 8'h00);
      chk("R7 still busy", status_byte, 8'hFF);
      finish_busy();
      chk("R8 done clears latch", status_byte, 8'h00);

      wren(1'b0);
      wr_seq(1'b1, 7'h00, 8'hF3 | 8'h04, g, a);
      chk("R9 status grant", {7'b0, g}, 8'h01);
      finish_busy();
      chk("R9 only code bits", status_byte, 8'h04);
      wren(1'b0);
      wr_seq(1'b1, 7'h00, 8'h00, g, a);
      finish_busy();
      chk("R9 code cleared", status_byte, 8'h00);

      wren(1'b0);
      cs_n = 1'b0; arr_arm = 1'b1; arr_page = 7'h05; tick();
      arr_arm = 1'b0; wp_n = 1'b0; tick();
      chk("R10 abort pulse", {7'b0, write_abort}, 8'h01);
      cs_n = 1'b1; tick();
      chk("R10 no grant after abort", {6'b0, commit_grant, write_abort}, 8'h00);
      wp_n = 1'b1; tick();
      chk("R10 latch kept", status_byte, 8'h02);

      wr_seq(1'b0, 7'h05, 8'h00, g, a);
      chk("R11 grant", {7'b0, g}, 8'h01);
      wp_n = 1'b0; cyc_busy = 1'b1; tick();
      chk("R11 no abort in cycle", {7'b0, write_abort}, 8'h00);
      chk("R11 still busy", status_byte, 8'hFF);
      cyc_busy = 1'b0; tick();
      chk("R11 completes", status_byte, 8'h00);
      wp_n = 1'b1; tick();

      foreach (VEC[i]) begin
         logic [1:0] code;
         logic [6:0] pg;
         logic       exp_g;
         {code, pg, exp_g} = VEC[i];
         wren(1'b0);
         wr_seq(1'b1, 7'h00, {4'b0000, code, 2'b00}, g, a);
         finish_busy();
         chk("R5 code set", status_byte, {4'b0000, code, 2'b00});
         wren(1'b0);
         wr_seq(1'b0, pg, 8'h00, g, a);
         chk("R5 protect map", {7'b0, g}, {7'b0, exp_g});
         if (g) begin
            finish_busy();
            chk("R5 after commit", status_byte, {4'b0000, code, 2'b00});
         end else begin
            chk("R5 refused keeps latch", status_byte, {4'b0000, code, 2'b10});
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule